// File: doc/BRIEF.md
# Nibble-Opcode Stack Processor

A small stack processor with 12-bit data and instruction words. Each instruction word carries three 4-bit opcodes, which run one after another from the most significant nibble down. Constants are not stored as full-word immediates. Eight digit opcodes each shift the top of the stack left by three bits and append an octal digit, so three digit opcodes in one word supply nine bits of constant. The remaining opcodes are:

- push-zero
- subtract
- NAND
- fetch from memory
- store to memory
- jump-if-zero
- no-op
- halt

The data stack holds two entries: a top and a second item.

The processor drives a single synchronous memory port. Read data returns on the cycle after an enabled read. The same port serves instruction fetch and data access. After reset the processor runs from word 0 until it executes a halt. The surrounding logic, or a testbench, then inspects what the program left in memory.

Top module: `nib_stack_cpu`

## Requirements
- R1: While rst_ni is low, halt_o and mem_we_o are low. On the first cycle after release, the port issues a read (mem_en_o high, mem_we_o low) of address 0.
- R2: The opcode in bits 11:8 of a word runs first, then bits 7:4, then bits 3:0. The program counter moves to the next word only after the third opcode, unless a jump is taken.
- R3: Opcodes 0 to 7 replace the top item with (top << 3) | opcode, truncated to 12 bits. The second item is unchanged.
- R4: Opcode 8 pushes zero. The old top becomes the second item.
- R5: Opcode 9 pops two items and pushes (second - top) modulo 4096.
- R6: Opcode 10 pops two items and pushes the bitwise NAND of them.
- R7: Opcode 11 reads the word whose address is the low 8 bits of the top item, and replaces the top with that word.
- R8: Opcode 12 writes the second item to the address given by the low 8 bits of the top item, and pops both.
- R9: Opcode 13 pops a target (the top) and a condition (the second item). When the condition is zero, the next access is an instruction read at the target, and any remaining opcodes in the current word are skipped. Otherwise execution continues in order.
- R10: Opcode 14 changes neither the stack nor memory.
- R11: Opcode 15 raises halt_o. halt_o then stays high, no further memory access takes place, and later opcodes do not run.
- R12: The stack is two entries deep. A push onto a full stack discards the old second item. Every pop refills the vacated entries with zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Write strobe, valid with mem_en_o |
| mem_addr_o | output | 8 | Word address |
| mem_wdata_o | output | 12 | Write data |
| mem_rdata_i | input | 12 | Read data, valid the cycle after a read |
| halt_o | output | 1 | High once a halt opcode has run |

## Verification
Internal state reaches the ports only through memory traffic and halt_o. A corrupt stack item therefore shows up as a wrong value or a wrong address on the next store. A corrupt slot counter or program counter shows up as a wrong instruction read address, or as opcodes skipped or repeated. Programs are arranged so that a store or a jump follows each operation closely, and each result is written to its own cell. A fault then appears in memory within a few cycles, or as an early or missing halt.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int OPC_W = 4;
  localparam int DIG_W = OPC_W - 1;

  typedef logic [OPC_W-1:0] opcode_t;

  localparam opcode_t OP_PUSH0 = 4'd8;
  localparam opcode_t OP_SUB   = 4'd9;
  localparam opcode_t OP_NAND  = 4'd10;
  localparam opcode_t OP_FETCH = 4'd11;
  localparam opcode_t OP_STORE = 4'd12;
  localparam opcode_t OP_JZ    = 4'd13;
  localparam opcode_t OP_NOP   = 4'd14;
  localparam opcode_t OP_HALT  = 4'd15;

  typedef enum logic [2:0] {
    STK_KEEP,
    STK_DIGIT,
    STK_PUSH,
    STK_LOAD_TOS,
    STK_FOLD,
    STK_CLEAR2
  } stk_op_e;

  typedef enum logic {ALU_SUB, ALU_NAND} alu_op_e;

  typedef enum logic [2:0] {
    S_IFETCH,
    S_ILOAD,
    S_EXEC,
    S_MWAIT,
    S_HALT
  } seq_state_e;

  typedef struct packed {
    stk_op_e stk;
    alu_op_e alu;
    logic    mem_rd;
    logic    mem_wr;
    logic    branch;
    logic    halt;
  } dec_t;
endpackage

// File: rtl/nib_alu.sv
module nib_alu
  import nib_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  alu_op_e           op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB:  y_o = a_i - b_i;
      ALU_NAND: y_o = ~(a_i & b_i);
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/nib_stack.sv
module nib_stack
  import nib_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stk_op_e           op_i,
  input  logic [WORD_W-1:0] val_i,
  input  logic [DIG_W-1:0]  digit_i,
  output logic [WORD_W-1:0] tos_o,
  output logic [WORD_W-1:0] nos_o
);
  localparam int KEEP_W = WORD_W - DIG_W;

  logic [WORD_W-1:0] tos_q, nos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tos_q <= '0;
      nos_q <= '0;
    end else begin
      unique case (op_i)
        STK_DIGIT:    tos_q <= {tos_q[KEEP_W-1:0], digit_i};
        STK_PUSH: begin
          nos_q <= tos_q;
          tos_q <= '0;
        end
        STK_LOAD_TOS: tos_q <= val_i;
        STK_FOLD: begin
          tos_q <= val_i;
          nos_q <= '0;
        end
        STK_CLEAR2: begin
          tos_q <= '0;
          nos_q <= '0;
        end
        default: ;
      endcase
    end
  end

  assign tos_o = tos_q;
  assign nos_o = nos_q;
endmodule

// File: rtl/nib_decode.sv
module nib_decode
  import nib_pkg::*;
(
  input  opcode_t op_i,
  output dec_t    dec_o
);
  always_comb begin
    dec_o = '{stk: STK_KEEP, alu: ALU_SUB, mem_rd: 1'b0, mem_wr: 1'b0,
              branch: 1'b0, halt: 1'b0};
    if (!op_i[OPC_W-1]) begin
      dec_o.stk = STK_DIGIT;
    end else begin
      unique case (op_i)
        OP_PUSH0: dec_o.stk = STK_PUSH;
        OP_SUB:   dec_o.stk = STK_FOLD;
        OP_NAND: begin
          dec_o.stk = STK_FOLD;
          dec_o.alu = ALU_NAND;
        end
        OP_FETCH: dec_o.mem_rd = 1'b1;
        OP_STORE: begin
          dec_o.stk    = STK_CLEAR2;
          dec_o.mem_wr = 1'b1;
        end
        OP_JZ: begin
          dec_o.stk    = STK_CLEAR2;
          dec_o.branch = 1'b1;
        end
        OP_HALT:  dec_o.halt = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/nib_seq.sv
module nib_seq
  import nib_pkg::*;
#(
  parameter int SLOTS  = 3,
  parameter int WORD_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stk_op_e           d_stk_i,
  input  logic              d_rd_i,
  input  logic              d_wr_i,
  input  logic              d_br_i,
  input  logic              d_halt_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic [WORD_W-1:0] nos_i,
  input  logic [WORD_W-1:0] rdata_i,
  output opcode_t           op_o,
  output logic              ex_valid_o,
  output stk_op_e           stk_op_o,
  output logic              val_mem_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              halt_o
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q;
  logic [SLOT_W-1:0] slot_q;
  logic              halt_q;
  opcode_t           slot_ops [SLOTS];

  // slot 0 sits in the most significant nibble
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_ops[g] = ir_q[WORD_W-1-g*OPC_W -: OPC_W];
  end

  assign op_o = slot_ops[slot_q];

  always_comb begin
    ex_valid_o  = 1'b0;
    stk_op_o    = STK_KEEP;
    val_mem_o   = 1'b0;
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = pc_q;
    mem_wdata_o = nos_i;
    unique case (state_q)
      S_IFETCH: mem_en_o = 1'b1;
      S_EXEC: begin
        ex_valid_o = 1'b1;
        stk_op_o   = d_stk_i;
        if (d_rd_i || d_wr_i) begin
          mem_en_o   = 1'b1;
          mem_we_o   = d_wr_i;
          mem_addr_o = tgt_i;
        end
      end
      S_MWAIT: begin
        stk_op_o  = STK_LOAD_TOS;
        val_mem_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IFETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      slot_q  <= '0;
      halt_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IFETCH: state_q <= S_ILOAD;
        S_ILOAD: begin
          ir_q    <= rdata_i;
          slot_q  <= '0;
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          if (d_halt_i) begin
            halt_q  <= 1'b1;
            state_q <= S_HALT;
          end else if (d_rd_i) begin
            state_q <= S_MWAIT;
          end else if (d_br_i && (nos_i == '0)) begin
            pc_q    <= tgt_i;
            state_q <= S_IFETCH;
          end else if (slot_q == LAST) begin
            pc_q    <= pc_q + 1'b1;
            state_q <= S_IFETCH;
          end else begin
            slot_q  <= slot_q + 1'b1;
          end
        end
        S_MWAIT: begin
          if (slot_q == LAST) begin
            pc_q    <= pc_q + 1'b1;
            state_q <= S_IFETCH;
          end else begin
            slot_q  <= slot_q + 1'b1;
            state_q <= S_EXEC;
          end
        end
        default: state_q <= S_HALT;
      endcase
    end
  end

  assign halt_o = halt_q;
endmodule

// File: rtl/nib_stack_cpu.sv
module nib_stack_cpu
  import nib_pkg::*;
#(
  parameter int SLOTS  = 3,
  parameter int ADDR_W = 8,
  localparam int WORD_W = SLOTS * OPC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              halt_o
);
  opcode_t           ex_op;
  logic              ex_valid;
  dec_t              dec;
  stk_op_e           stk_op;
  logic              val_mem;
  logic [WORD_W-1:0] tos, nos, alu_y, stk_val;

  nib_decode u_dec (
    .op_i  (ex_op),
    .dec_o (dec)
  );

  nib_seq #(.SLOTS(SLOTS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .d_stk_i     (dec.stk),
    .d_rd_i      (dec.mem_rd),
    .d_wr_i      (dec.mem_wr),
    .d_br_i      (dec.branch),
    .d_halt_i    (dec.halt),
    .tgt_i       (tos[ADDR_W-1:0]),
    .nos_i       (nos),
    .rdata_i     (mem_rdata_i),
    .op_o        (ex_op),
    .ex_valid_o  (ex_valid),
    .stk_op_o    (stk_op),
    .val_mem_o   (val_mem),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .halt_o      (halt_o)
  );

  nib_alu #(.WORD_W(WORD_W)) u_alu (
    .op_i (dec.alu),
    .a_i  (nos),
    .b_i  (tos),
    .y_o  (alu_y)
  );

  assign stk_val = val_mem ? mem_rdata_i : alu_y;

  nib_stack #(.WORD_W(WORD_W)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (stk_op),
    .val_i   (stk_val),
    .digit_i (ex_op[DIG_W-1:0]),
    .tos_o   (tos),
    .nos_o   (nos)
  );
endmodule

// File: rtl/nib_stack_cpu_chk.sv
module nib_stack_cpu_chk
  import nib_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              ex_valid,
  input opcode_t           ex_op,
  input logic [WORD_W-1:0] tos,
  input logic [WORD_W-1:0] nos
);
  localparam int KEEP_W = WORD_W - DIG_W;

  // R11
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);

  // R11
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !mem_en_o);

  // R8
  we_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o);

  // R3
  digit_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid && !ex_op[OPC_W-1]) |=>
      (tos == {$past(tos[KEEP_W-1:0]), $past(ex_op[DIG_W-1:0])}) && $stable(nos));

  // R5
  sub_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid && ex_op == OP_SUB) |=> tos == WORD_W'($past(nos) - $past(tos)));

  // R9
  jz_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid && ex_op == OP_JZ && nos == '0) |=>
      (mem_en_o && !mem_we_o && mem_addr_o == $past(tos[ADDR_W-1:0])));

  // R12
  pop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid && ex_op == OP_STORE) |=> (tos == '0 && nos == '0));
endmodule

bind nib_stack_cpu nib_stack_cpu_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halt_o     (halt_o),
  .mem_en_o   (mem_en_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .ex_valid   (ex_valid),
  .ex_op      (ex_op),
  .tos        (tos),
  .nos        (nos)
);

// File: tb/nib_stack_cpu_tb.sv
module nib_stack_cpu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 12;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [WORD_W-1:0] FILL = 12'h5A5;
  localparam logic [3:0] PUSH0 = 4'd8, SUB = 4'd9, NAND = 4'd10, FETCH = 4'd11,
                         STORE = 4'd12, JZ = 4'd13, NOP = 4'd14, HALT = 4'd15;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mem_en_o, mem_we_o, halt_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [WORD_W-1:0] mem_wdata_o;
  logic [WORD_W-1:0] mem_rdata_i = '0;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [3:0] pq [DEPTH*3];
  int pn;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nib_stack_cpu #(.SLOTS(3), .ADDR_W(ADDR_W)) u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .halt_o      (halt_o)
  );

  always @(posedge clk_i) begin
    if (mem_en_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata_i     <= mem[mem_addr_o];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic emit(input logic [3:0] op);
    pq[pn] = op;
    pn++;
  endtask

  task automatic org(input int w);
    while (pn < w*3) emit(NOP);
  endtask

  task automatic lit(input int v);
    emit(PUSH0);
    for (int i = 3; i >= 0; i--) emit(4'((v >> (3*i)) & 7));
  endtask

  task automatic put(input int v, input int a);
    lit(v);
    lit(a);
    emit(STORE);
  endtask

  task automatic prog_new();
    pn = 0;
    rst_ni = 1'b0;
    for (int i = 0; i < DEPTH; i++) mem[i] = FILL;
  endtask

  task automatic boot();
    emit(HALT);
    while (pn % 3 != 0) emit(NOP);
    for (int w = 0; w < pn/3; w++) mem[w] = {pq[3*w], pq[3*w+1], pq[3*w+2]};
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run(input string req);
    int n = 0;
    @(negedge clk_i);
    while (!halt_o && n < 3000) begin
      @(negedge clk_i);
      n++;
    end
    chk(halt_o, req, int'(halt_o), 1);
  endtask

  task automatic t_reset();
    prog_new();
    @(negedge clk_i);
    chk(!halt_o && !mem_we_o, "R1 reset outputs", int'({halt_o, mem_we_o}), 0);
    boot();
    chk(mem_en_o && !mem_we_o && mem_addr_o == 0, "R1 first read",
        int'(mem_addr_o), 0);
    run("R11 halt rises");
  endtask

  task automatic t_digits();
    prog_new();
    put(12'o1234, 128);
    emit(PUSH0); emit(7); emit(7); emit(7); emit(7); emit(5);
    lit(129); emit(STORE);
    boot();
    run("R2 program completes");
    chk(mem[128] == 12'o1234, "R3/R2 digit order", int'(mem[128]), 12'o1234);
    chk(mem[129] == 12'o7775, "R3 truncation", int'(mem[129]), 12'o7775);
  endtask

  task automatic t_stack();
    prog_new();
    emit(PUSH0); emit(3); emit(PUSH0); emit(4);
    lit(130); emit(STORE);
    emit(2); emit(1); emit(0); emit(STORE);   // address 136, value from cleared entry
    boot();
    run("R4 program completes");
    chk(mem[130] == 4, "R4/R12 push keeps top as second", int'(mem[130]), 4);
    chk(mem[136] == 0, "R12 pop fills zero", int'(mem[136]), 0);
  endtask

  task automatic t_alu();
    prog_new();
    lit(10); lit(3); emit(SUB); lit(140); emit(STORE);
    lit(3); lit(10); emit(SUB); lit(141); emit(STORE);
    lit(12'o7070); lit(12'o7700); emit(NAND); lit(142); emit(STORE);
    lit(0); lit(0); emit(NAND); lit(143); emit(STORE);
    boot();
    run("R5 program completes");
    chk(mem[140] == 7, "R5 sub", int'(mem[140]), 7);
    chk(mem[141] == 4089, "R5 sub wrap", int'(mem[141]), 4089);
    chk(mem[142] == 12'o0777, "R6 nand", int'(mem[142]), 12'o0777);
    chk(mem[143] == 12'o7777, "R6 nand zero", int'(mem[143]), 12'o7777);
  endtask

  task automatic t_fetch_nop();
    prog_new();
    lit(160); emit(FETCH); lit(161); emit(STORE);
    lit(12'o7240); emit(FETCH); lit(162); emit(STORE);
    emit(PUSH0); emit(1); emit(NOP); emit(2); emit(NOP); emit(NOP); emit(3);
    lit(163); emit(STORE);
    boot();
    mem[160] = 12'o4321;
    run("R7 program completes");
    chk(mem[161] == 12'o4321, "R7 fetch", int'(mem[161]), 12'o4321);
    chk(mem[162] == 12'o4321, "R7 fetch low address bits", int'(mem[162]), 12'o4321);
    chk(mem[163] == 12'o123, "R10 nop", int'(mem[163]), 12'o123);
  endtask

  task automatic t_jump();
    prog_new();
    lit(0); lit(40); emit(JZ); emit(HALT);     // JZ in slot 1, HALT in slot 2
    org(40);
    put(2, 150);
    lit(1); lit(60); emit(JZ);
    put(3, 151);
    boot();
    run("R9 program completes");
    chk(mem[150] == 2, "R9 taken jump skips rest of word", int'(mem[150]), 2);
    chk(mem[151] == 3, "R9 not taken falls through", int'(mem[151]), 3);
  endtask

  task automatic t_halt();
    int bad = 0;
    prog_new();
    emit(HALT);
    put(7, 170);
    boot();
    run("R11 halt");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (mem_en_o || !halt_o) bad++;
    end
    chk(bad == 0, "R11 quiet and sticky after halt", bad, 0);
    chk(mem[170] == FILL, "R11 later opcodes skipped", int'(mem[170]), int'(FILL));
  endtask

  initial begin
    t_reset();
    t_digits();
    t_stack();
    t_alu();
    t_fetch_nop();
    t_jump();
    t_halt();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule